// File: doc/BRIEF.md
# Serial Register Master for a Display Controller

This block turns single host requests into the framed byte sequences that a display controller expects on a four-wire serial link with 8-bit frames. A request is one of four operations: write a 16-bit register, read a 16-bit register, read the 16-bit status word, or point the controller at its pixel-memory data port. The block builds every byte, drives the serial clock, data out and the active-low chip select, samples the data-in line, and returns read data together with a one-cycle completion strobe.

Each frame opens with a start byte carrying a device identifier bit, a target bit (index register versus data) and a direction bit. A register access takes two frames with chip select released between them: the index frame, then the value frame. The identifier bit and transmit inversion are inputs taken with each request. The serial clock is derived from the system clock by a divider computed from the system frequency and the highest register-access rate.

The sequencer has five states. ST_IDLE waits for a request (transition "accept"). ST_SETUP holds chip select low for one half period and then loads the first byte ("first byte"). ST_SHIFT runs bytes back to back ("next byte") until the last byte of the frame ("frame end"). ST_GAP keeps chip select high for the minimum gap and then either opens the next frame ("next frame") or finishes ("finish"). ST_DONE pulses the strobe for one cycle and returns to ST_IDLE ("release").

Top module: `dspi_reg_master`

## Requirements
- R1: Every frame begins with a start byte equal to 0x70 + 4*id + 2*target + dir, where target 0 is the index register, target 1 is register or pixel data, dir 0 is write and dir 1 is read; all bytes go out most significant bit first.
- R2: Operation code 0 (register write) sends two frames: {start(target 0, dir 0), 0x00, index}, then {start(target 1, dir 0), value high byte, value low byte}.
- R3: Operation code 1 (register read) sends the same index frame, then {start(target 1, dir 1), 0x00, 0x00}; the read result is the byte received during the second byte of the value frame as high byte and the third as low byte.
- R4: Operation code 2 (status read) sends one four-byte frame {start(target 0, dir 1), 0x00, 0x00, 0x00}; the byte received right after the start byte is discarded and the result is received byte 3 as high byte and byte 4 as low byte.
- R5: Operation code 3 (pixel-memory select) sends only {start(target 0, dir 0), 0x00, 0x22}, ignores the index and value inputs, and is never inverted.
- R6: When tx_invert is 1 at acceptance, every transmitted byte of operation codes 0 to 2 is the bitwise complement of its plain value.
- R7: The link runs in clock mode 0: data out changes only while the serial clock is low, data in is sampled on its rising edge, and each serial clock half period lasts exactly ceil(SYS_CLK_HZ / (2*SCLK_MAX_HZ)) system cycles (25 with default parameters, i.e. 4 MHz).
- R8: The serial clock is low whenever chip select is high, and chip select stays high for at least 2*GAP_SCLK_PERIODS half periods between frames (100 system cycles by default).
- R9: busy rises the cycle after a request is accepted and stays high until done; done is a single-cycle pulse after which busy is low; a request made while busy is ignored.
- R10: After reset cs_n is 1, sclk is 0, busy is 0, done is 0 and rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_op | input | 2 | Operation code: 0 write, 1 read, 2 status, 3 pixel-memory select |
| req_index | input | 8 | Register index |
| req_wdata | input | 16 | Value for a register write |
| dev_id | input | 1 | Device identifier bit placed in start bytes |
| tx_invert | input | 1 | Complement all transmitted bytes of this request |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion strobe |
| rdata | output | 16 | Result of the last register or status read |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the controller |
| miso | input | 1 | Serial data from the controller |
| cs_n | output | 1 | Active-low chip select |

## Verification
A wrong byte or frame counter shows as a malformed frame on mosi within the current frame: a byte too many or too few, a wrong start byte, or a missing second frame, seen at the next rise of cs_n. A wrong capture position shows as rdata holding the junk byte or a dummy-time byte after done. A wrong state in the sequencer shows as a cs_n gap shorter than the minimum, sclk moving while deselected, or a done pulse that is wide, missing, or leaves busy high, all visible within one half period of the fault.

// File: rtl/dspi_pkg.sv
package dspi_pkg;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_READ   = 2'd1,
        OP_STATUS = 2'd2,
        OP_PIXSEL = 2'd3
    } dspi_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_GAP,
        ST_DONE
    } dspi_state_e;

    localparam logic [4:0] START_PREFIX = 5'b01110;
    localparam logic [7:0] PIXMEM_INDEX = 8'h22;

    function automatic logic [7:0] start_byte(input logic id, input logic target, input logic dir);
        return {START_PREFIX, id, target, dir};
    endfunction

endpackage

// File: rtl/dspi_tick_gen.sv
module dspi_tick_gen #(
    parameter int unsigned HALF_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == CW'(HALF_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dspi_byte_shifter.sv
module dspi_byte_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       load,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    logic [7:0] tx_sr;
    logic [7:0] rx_sr;
    logic [2:0] bit_q;
    logic       active_q;
    logic       sclk_q;

    assign sclk      = sclk_q;
    assign mosi      = tx_sr[7];
    assign rx_byte   = rx_sr;
    assign byte_done = active_q && tick && sclk_q && (bit_q == 3'd7);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr    <= '0;
            rx_sr    <= '0;
            bit_q    <= '0;
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
        end else if (load) begin
            tx_sr    <= tx_byte;
            bit_q    <= '0;
            active_q <= 1'b1;
            sclk_q   <= 1'b0;
        end else if (active_q && tick) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
                rx_sr  <= {rx_sr[6:0], miso};
            end else begin
                sclk_q <= 1'b0;
                if (bit_q == 3'd7) begin
                    active_q <= 1'b0;
                end else begin
                    bit_q <= bit_q + 1'b1;
                    tx_sr <= {tx_sr[6:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/dspi_reg_master.sv
module dspi_reg_master
    import dspi_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ       = 200_000_000,
    parameter int unsigned SCLK_MAX_HZ      = 4_000_000,
    parameter int unsigned GAP_SCLK_PERIODS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic [7:0]  req_index,
    input  logic [15:0] req_wdata,
    input  logic        dev_id,
    input  logic        tx_invert,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n
);
    localparam int unsigned HALF_DIV   = (SYS_CLK_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
    localparam int unsigned GAP_HALVES = 2 * GAP_SCLK_PERIODS;
    localparam int unsigned GW         = (GAP_HALVES > 1) ? $clog2(GAP_HALVES) : 1;

    dspi_state_e state_q, state_d;
    dspi_op_e    op_q;
    logic [7:0]  idx_q;
    logic [15:0] wd_q;
    logic        id_q, inv_q;
    logic        frame_q;
    logic [1:0]  byte_q;
    logic [GW-1:0] gap_q;
    logic [15:0] rdata_q;

    logic        tick, load, byte_done;
    logic [7:0]  tx_byte, rx_byte, raw_byte;
    logic [1:0]  sel;
    logic        last_byte, last_frame, gap_end;

    assign last_byte  = (op_q == OP_STATUS) ? (byte_q == 2'd3) : (byte_q == 2'd2);
    assign last_frame = (op_q == OP_WRITE || op_q == OP_READ) ? frame_q : 1'b1;
    assign gap_end    = tick && (gap_q == GW'(GAP_HALVES - 1));
    assign load       = ((state_q == ST_SETUP) && tick)
                     || ((state_q == ST_SHIFT) && byte_done && !last_byte);

    dspi_tick_gen #(.HALF_DIV(HALF_DIV)) i_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state_q != ST_IDLE),
        .tick (tick)
    );

    dspi_byte_shifter i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (load),
        .tx_byte  (tx_byte),
        .miso     (miso),
        .sclk     (sclk),
        .mosi     (mosi),
        .byte_done(byte_done),
        .rx_byte  (rx_byte)
    );

    // byte to load: first byte of a frame from ST_SETUP, otherwise the following one
    always_comb begin
        sel = (state_q == ST_SETUP) ? 2'd0 : byte_q + 2'd1;
        if (sel == 2'd0) begin
            raw_byte = start_byte(id_q, frame_q,
                                  (op_q == OP_STATUS) || ((op_q == OP_READ) && frame_q));
        end else if (!frame_q) begin
            if (sel == 2'd2 && op_q == OP_PIXSEL)      raw_byte = PIXMEM_INDEX;
            else if (sel == 2'd2 && op_q != OP_STATUS) raw_byte = idx_q;
            else                                       raw_byte = 8'h00;
        end else if (op_q == OP_WRITE) begin
            raw_byte = (sel == 2'd1) ? wd_q[15:8] : wd_q[7:0];
        end else begin
            raw_byte = 8'h00;
        end
        tx_byte = raw_byte ^ {8{inv_q && (op_q != OP_PIXSEL)}};
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_SETUP;
            ST_SETUP: if (tick) state_d = ST_SHIFT;
            ST_SHIFT: if (byte_done && last_byte) state_d = ST_GAP;
            ST_GAP:   if (gap_end) state_d = last_frame ? ST_DONE : ST_SETUP;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        cs_n = 1'b1;
        busy = 1'b1;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_SETUP: cs_n = 1'b0;
            ST_SHIFT: cs_n = 1'b0;
            ST_GAP:   cs_n = 1'b1;
            ST_DONE:  done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_WRITE;
            idx_q   <= '0;
            wd_q    <= '0;
            id_q    <= 1'b0;
            inv_q   <= 1'b0;
            frame_q <= 1'b0;
            byte_q  <= '0;
            gap_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                op_q    <= dspi_op_e'(req_op);
                idx_q   <= req_index;
                wd_q    <= req_wdata;
                id_q    <= dev_id;
                inv_q   <= tx_invert;
                frame_q <= 1'b0;
                byte_q  <= '0;
                gap_q   <= '0;
            end
            if (state_q == ST_SHIFT && byte_done) begin
                if (op_q == OP_READ && frame_q && byte_q == 2'd1)   rdata_q[15:8] <= rx_byte;
                if (op_q == OP_READ && frame_q && byte_q == 2'd2)   rdata_q[7:0]  <= rx_byte;
                if (op_q == OP_STATUS && byte_q == 2'd2)            rdata_q[15:8] <= rx_byte;
                if (op_q == OP_STATUS && byte_q == 2'd3)            rdata_q[7:0]  <= rx_byte;
                byte_q <= last_byte ? 2'd0 : byte_q + 2'd1;
            end
            if (state_q == ST_GAP && tick) begin
                if (gap_end) begin
                    gap_q   <= '0;
                    frame_q <= 1'b1;
                end else begin
                    gap_q <= gap_q + 1'b1;
                end
            end
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/dspi_reg_master_chk.sv
module dspi_reg_master_chk #(
    parameter int unsigned HALF_DIV   = 25,
    parameter int unsigned GAP_HALVES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic sclk,
    input logic mosi,
    input logic cs_n
);
    localparam int unsigned GAP_MIN = GAP_HALVES * HALF_DIV;

    logic        sclk_q, cs_q;
    int unsigned half_cnt, gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            cs_q     <= 1'b1;
            half_cnt <= HALF_DIV;
            gap_cnt  <= GAP_MIN;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
            if (sclk != sclk_q)         half_cnt <= 1;
            else if (half_cnt < HALF_DIV) half_cnt <= half_cnt + 1;
            if (cs_n != cs_q)           gap_cnt <= 1;
            else if (gap_cnt < GAP_MIN) gap_cnt <= gap_cnt + 1;
        end
    end

    AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R8
    AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n) (!cs_n && cs_q) |-> (gap_cnt >= GAP_MIN)); // R8
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (sclk && sclk_q) |-> $stable(mosi)); // R7
    AST_HALF_PERIOD_MIN: assert property (@(posedge clk) disable iff (!rst_n) (sclk != sclk_q) |-> (half_cnt >= HALF_DIV)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R9
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy); // R9
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !busy) |=> busy); // R9
endmodule

bind dspi_reg_master dspi_reg_master_chk #(
    .HALF_DIV  (HALF_DIV),
    .GAP_HALVES(GAP_HALVES)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .busy     (busy),
    .done     (done),
    .sclk     (sclk),
    .mosi     (mosi),
    .cs_n     (cs_n)
);

// File: tb/test_dspi_reg_master.sv
module test_dspi_reg_master;
    localparam int HALF = 25;
    localparam int GAP  = 4 * HALF;
    localparam int NV   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [7:0]  req_index = 8'h00;
    logic [15:0] req_wdata = 16'h0000;
    logic        dev_id = 1'b0;
    logic        tx_invert = 1'b0;
    logic        busy, done, sclk, mosi, cs_n;
    logic        miso;
    logic [15:0] rdata;

    always #2.5 clk = ~clk;

    dspi_reg_master i_dspi_reg_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_index(req_index), .req_wdata(req_wdata), .dev_id(dev_id),
        .tx_invert(tx_invert), .busy(busy), .done(done), .rdata(rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int checks = 0;
    int errors = 0;

    // controller model: logs frames, answers on miso, measures timing
    logic [31:0] resp = 32'h0;
    logic [31:0] fr_data [64];
    int          fr_bits [64];
    int          fr_cnt = 0;
    logic [31:0] cur_data = 0;
    int          cur_bits = 0;
    int          bitpos = 0;
    logic        miso_r = 1'b0;
    logic        p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;
    int          half_cnt = 1000, gap_cnt = 1000;
    int          min_half = 1000, min_gap = 1000;
    int          sclk_desel = 0, mosi_hi_move = 0;

    assign miso = miso_r;

    always @(negedge clk) begin
        if (cs_n && !p_cs) begin
            fr_data[fr_cnt % 64] = cur_data;
            fr_bits[fr_cnt % 64] = cur_bits;
            fr_cnt   = fr_cnt + 1;
            gap_cnt  = 1;
        end else if (cs_n) begin
            gap_cnt = gap_cnt + 1;
        end
        if (!cs_n && p_cs) begin
            if (gap_cnt < min_gap) min_gap = gap_cnt;
            cur_data = 0;
            cur_bits = 0;
            bitpos   = 0;
        end
        if (sclk != p_sclk) begin
            if (!cs_n && half_cnt < min_half) min_half = half_cnt;
            half_cnt = 1;
        end else begin
            half_cnt = half_cnt + 1;
        end
        if (!cs_n && sclk && !p_sclk) begin
            cur_data = {cur_data[30:0], mosi};
            cur_bits = cur_bits + 1;
        end
        if (!cs_n && !sclk && p_sclk) bitpos = bitpos + 1;
        if (cs_n && sclk) sclk_desel = sclk_desel + 1;
        if (sclk && p_sclk && mosi != p_mosi) mosi_hi_move = mosi_hi_move + 1;
        miso_r = (bitpos < 32) ? resp[31 - bitpos] : 1'b0;
        p_sclk = sclk;
        p_cs   = cs_n;
        p_mosi = mosi;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sb(input logic id, input int target, input int dir);
        return 8'h70 + 8'(id) * 8'd4 + 8'(target * 2 + dir);
    endfunction

    function automatic int exp_frames(input logic [1:0] op);
        return (op <= 2'd1) ? 2 : 1;
    endfunction

    function automatic logic [31:0] exp_frame(input logic [1:0] op, input logic id, input logic inv,
                                              input logic [7:0] idx, input logic [15:0] wd, input int k);
        logic [7:0] x;
        x = (inv && op != 2'd3) ? 8'hFF : 8'h00;
        case (op)
            2'd0: return (k == 0) ? {8'h0, sb(id,0,0) ^ x, x, idx ^ x}
                                  : {8'h0, sb(id,1,0) ^ x, wd[15:8] ^ x, wd[7:0] ^ x};
            2'd1: return (k == 0) ? {8'h0, sb(id,0,0) ^ x, x, idx ^ x}
                                  : {8'h0, sb(id,1,1) ^ x, x, x};
            2'd2: return {sb(id,0,1) ^ x, x, x, x};
            default: return {8'h0, sb(id,0,0), 8'h00, 8'h22};
        endcase
    endfunction

    // {op, id, inv, index, wdata, controller response}
    localparam logic [59:0] VEC [NV] = '{
        {2'd0, 1'b1, 1'b0, 8'h10, 16'h4240, 32'h0000_0000},
        {2'd0, 1'b0, 1'b1, 8'h01, 16'h691B, 32'h0000_0000},
        {2'd1, 1'b1, 1'b0, 8'h00, 16'h0000, 32'hA592_213C},
        {2'd1, 1'b0, 1'b1, 8'h45, 16'h0000, 32'h5ADB_0077},
        {2'd2, 1'b1, 1'b0, 8'h00, 16'h0000, 32'hFFEE_1234},
        {2'd2, 1'b0, 1'b1, 8'h00, 16'h0000, 32'h0081_C3A5},
        {2'd3, 1'b1, 1'b1, 8'h5C, 16'hBEEF, 32'h0000_0000},
        {2'd3, 1'b0, 1'b0, 8'h99, 16'h1234, 32'h0000_0000}
    };

    task automatic issue(input logic [1:0] op, input logic id, input logic inv,
                         input logic [7:0] idx, input logic [15:0] wd);
        @(negedge clk);
        req_op = op; dev_id = id; tx_invert = inv; req_index = idx; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 cs_n", 32'(cs_n), 32'd1);
        chk("R10 sclk", 32'(sclk), 32'd0);
        chk("R10 busy", 32'(busy), 32'd0);
        chk("R10 done", 32'(done), 32'd0);
        chk("R10 rdata", 32'(rdata), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [1:0]  op;
            logic        id, inv;
            logic [7:0]  idx;
            logic [15:0] wd;
            int          base;
            op = VEC[v][59:58]; id = VEC[v][57]; inv = VEC[v][56];
            idx = VEC[v][55:48]; wd = VEC[v][47:32];
            resp = VEC[v][31:0];
            base = fr_cnt;
            issue(op, id, inv, idx, wd);
            chk("R9 busy after accept", 32'(busy), 32'd1);
            wait_done();
            chk("R9 done seen", 32'(done), 32'd1);
            @(negedge clk);
            chk("R9 done one cycle", 32'(done), 32'd0);
            chk("R9 busy cleared", 32'(busy), 32'd0);
            chk("R2 R3 R4 R5 frame count", 32'(fr_cnt - base), 32'(exp_frames(op)));
            for (int k = 0; k < exp_frames(op); k++) begin
                chk("R1 R6 frame length", 32'(fr_bits[(base + k) % 64]), (op == 2'd2) ? 32'd32 : 32'd24);
                case (op)
                    2'd0: chk("R2 R1 R6 write frame", fr_data[(base + k) % 64], exp_frame(op, id, inv, idx, wd, k));
                    2'd1: chk("R3 R1 R6 read frame", fr_data[(base + k) % 64], exp_frame(op, id, inv, idx, wd, k));
                    2'd2: chk("R4 R1 R6 status frame", fr_data[(base + k) % 64], exp_frame(op, id, inv, idx, wd, k));
                    default: chk("R5 pixel select frame", fr_data[(base + k) % 64], exp_frame(op, id, inv, idx, wd, k));
                endcase
            end
            if (op == 2'd1) chk("R3 read result", 32'(rdata), 32'(resp[23:8]));
            if (op == 2'd2) chk("R4 status result", 32'(rdata), 32'(resp[15:0]));
        end

        // R9: a request while busy is ignored
        begin
            int base;
            resp = 32'h0;
            base = fr_cnt;
            issue(2'd0, 1'b1, 1'b0, 8'h12, 16'h0014);
            repeat (50) @(negedge clk);
            issue(2'd2, 1'b0, 1'b1, 8'h00, 16'h0000);
            wait_done();
            repeat (400) @(negedge clk);
            chk("R9 busy request ignored frames", 32'(fr_cnt - base), 32'd2);
            chk("R9 busy request ignored idle", 32'(busy), 32'd0);
            chk("R9 busy request ignored cs_n", 32'(cs_n), 32'd1);
            chk("R9 first request intact", fr_data[(base + 1) % 64], exp_frame(2'd0, 1'b1, 1'b0, 8'h12, 16'h0014, 1));
        end

        // R7 / R8 timing collected by the model
        chk("R7 half period", 32'(min_half), 32'(HALF));
        chk("R7 mosi moves only while low", 32'(mosi_hi_move), 32'd0);
        chk("R8 cs gap", 32'(min_gap >= GAP), 32'd1);
        chk("R8 sclk low when deselected", 32'(sclk_desel), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog R9 actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
        $finish;
    end
endmodule